// File: doc/BRIEF.md
# Clock Victim Selector with Dirty Tracking

This block picks which of a set of page frames gives up its page when a new one must be brought in. Every frame keeps three flags: a use flag, a write flag and a sticky modified flag. Memory references reported on the reference port raise the use flag, and writes also raise the write flag. When a replacement is requested, a circular hand visits one frame per clock cycle. It lowers flags on frames that were recently touched and stops at the first frame that has no recent activity.

Two policies are available through a mode input. Second-chance looks only at the use flag. Third-chance gives written frames one more pass: when it clears a frame's write flag, it sets the sticky modified flag so that the write-back need is not lost. When a victim is found, the block pulses `done`, reports the frame index and whether that frame must be written back, and marks the frame as freshly loaded. The hand then rests on the next frame, ready for the following request.

Top module: `clock_victim_sel`

## Requirements
- R1: A reference sets the use flag of its frame. The write flag is set only when `ref_write` is 1. A read leaves an already-set write flag unchanged.
- R2: With `mode_third`=1, the hand examines a frame and applies these transitions to its (use, write) pair, then advances: 11 becomes 01 and 10 becomes 00. In both cases the modified flag is kept.
- R3: With `mode_third`=1, a frame at (use, write)=01 becomes 00 and its modified flag is set. A later selection of that frame reports `victim_dirty`=1.
- R4: A frame at (use, write)=00 in third-chance mode is selected. `done` is high for exactly one cycle, `victim` gives its index, and `victim_dirty` is the OR of its write and modified flags.
- R5: With `mode_third`=0, a frame with use=0 is selected. Otherwise its use flag is cleared, its write flag is left alone and the hand moves on, wrapping from the last frame to frame 0.
- R6: A `req` sampled while idle raises `busy` on the next cycle. One frame is examined per cycle. When the victim is found at the k-th examination, `done` rises and `busy` falls k cycles after the accepting edge.
- R7: After a selection, the hand points at the frame that follows the victim (circularly). The next sweep starts there.
- R8: The selected frame is loaded: use=1, write=0, modified=0. It is therefore not chosen again on the very next request unless every other frame is busier.
- R9: A reference that arrives during a sweep and targets a frame not yet examined takes effect before that frame is examined.
- R10: In third-chance mode a sweep needs at most 2N+1 examinations, which is within three revolutions. The bound is reached when every frame starts at (use, write)=11.
- R11: After reset all flags are 0, the hand is on frame 0, and `busy` and `done` are 0. A first request therefore selects frame 0 after one examination, with `victim_dirty`=0.
- R12: `req` is ignored while `busy` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_third | input | 1 | 1 = third-chance policy, 0 = second-chance policy |
| ref_valid | input | 1 | A frame reference is reported this cycle |
| ref_frame | input | IDX_W | Index of the referenced frame |
| ref_write | input | 1 | The reference is a write |
| req | input | 1 | Request a victim |
| busy | output | 1 | Sweep in progress |
| done | output | 1 | One-cycle pulse: victim is valid |
| victim | output | IDX_W | Index of the selected frame |
| victim_dirty | output | 1 | Selected frame needs write-back |

## Verification
The hardest case to reach is a reference that lands in the middle of a sweep on a frame the hand has not reached yet. Without such a reference, that frame would be selected. The bench starts a sweep in which only the last frame is idle. It then reports a read to that frame on exactly the cycle the second frame is examined. The sweep must wrap around and select frame 0 instead. The longest sweep is reached by writing every frame before the request. The stray-request case is reached by pulsing `req` halfway through that long sweep.

// File: rtl/cvs_pkg.sv
package cvs_pkg;

   typedef struct packed {
      logic used;
      logic wr;
      logic modf;
   } frame_bits_t;

   localparam frame_bits_t FRESH_LOAD = '{used: 1'b1, wr: 1'b0, modf: 1'b0};
   localparam frame_bits_t ALL_CLEAR  = '{used: 1'b0, wr: 1'b0, modf: 1'b0};

   typedef enum logic {ST_IDLE = 1'b0, ST_SWEEP = 1'b1} sweep_state_e;

endpackage

// File: rtl/cvs_grader.sv
module cvs_grader
   import cvs_pkg::*;
(
   input  frame_bits_t cur,
   input  logic        mode_third,
   output frame_bits_t nxt,
   output logic        pick
);
   always_comb begin
      nxt  = cur;
      pick = 1'b0;
      if (mode_third) begin
         unique case ({cur.used, cur.wr})
            2'b11: begin nxt.used = 1'b0; end
            2'b10: begin nxt.used = 1'b0; end
            2'b01: begin nxt.wr = 1'b0; nxt.modf = 1'b1; end
            default: pick = 1'b1;
         endcase
      end else begin
         if (cur.used) nxt.used = 1'b0;
         else          pick     = 1'b1;
      end
   end
endmodule

// File: rtl/cvs_frame_store.sv
module cvs_frame_store
   import cvs_pkg::*;
#(
   parameter int NFRAMES = 8,
   localparam int IDX_W  = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      ref_valid,
   input  logic [IDX_W-1:0]          ref_frame,
   input  logic                      ref_write,
   input  logic                      upd_en,
   input  logic [IDX_W-1:0]          upd_idx,
   input  frame_bits_t               upd_bits,
   output frame_bits_t [NFRAMES-1:0] frames
);
   for (genvar g = 0; g < NFRAMES; g++) begin : g_frame
      logic hit_ref, hit_upd;
      assign hit_ref = ref_valid && (ref_frame == IDX_W'(g));
      assign hit_upd = upd_en    && (upd_idx   == IDX_W'(g));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            frames[g] <= ALL_CLEAR;
         end else if (hit_upd) begin
            frames[g] <= upd_bits;
         end else if (hit_ref) begin
            frames[g].used <= 1'b1;
            if (ref_write) frames[g].wr <= 1'b1;
         end
      end
   end
endmodule

// File: rtl/cvs_hand.sv
module cvs_hand #(
   parameter int NFRAMES = 8,
   localparam int IDX_W  = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             advance,
   output logic [IDX_W-1:0] ptr
);
   localparam logic [IDX_W-1:0] LAST = IDX_W'(NFRAMES - 1);

   always_ff @(posedge clk) begin
      if (!rst_n)       ptr <= '0;
      else if (advance) ptr <= (ptr == LAST) ? '0 : ptr + 1'b1;
   end
endmodule

// File: rtl/clock_victim_sel.sv
module clock_victim_sel
   import cvs_pkg::*;
#(
   parameter int NFRAMES = 8,
   localparam int IDX_W  = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             mode_third,
   input  logic             ref_valid,
   input  logic [IDX_W-1:0] ref_frame,
   input  logic             ref_write,
   input  logic             req,
   output logic             busy,
   output logic             done,
   output logic [IDX_W-1:0] victim,
   output logic             victim_dirty
);
   if (NFRAMES < 2) begin : g_bad_n
      $error("clock_victim_sel: NFRAMES must be at least 2");
   end

   sweep_state_e              state_q;
   frame_bits_t [NFRAMES-1:0] frames;
   logic [IDX_W-1:0]          ptr;
   frame_bits_t               cur, graded, upd_bits;
   logic                      pick, sweeping;

   assign sweeping = (state_q == ST_SWEEP);
   assign busy     = sweeping;

   always_comb begin
      cur = frames[ptr];
      if (ref_valid && ref_frame == ptr) begin
         cur.used = 1'b1;
         if (ref_write) cur.wr = 1'b1;
      end
   end

   cvs_grader u_grader (.cur(cur), .mode_third(mode_third), .nxt(graded), .pick(pick));

   assign upd_bits = pick ? FRESH_LOAD : graded;

   cvs_frame_store #(.NFRAMES(NFRAMES)) u_store (
      .clk(clk), .rst_n(rst_n),
      .ref_valid(ref_valid), .ref_frame(ref_frame), .ref_write(ref_write),
      .upd_en(sweeping), .upd_idx(ptr), .upd_bits(upd_bits),
      .frames(frames)
   );

   cvs_hand #(.NFRAMES(NFRAMES)) u_hand (
      .clk(clk), .rst_n(rst_n), .advance(sweeping), .ptr(ptr)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q      <= ST_IDLE;
         done         <= 1'b0;
         victim       <= '0;
         victim_dirty <= 1'b0;
      end else begin
         done <= 1'b0;
         unique case (state_q)
            ST_IDLE: if (req) state_q <= ST_SWEEP;
            ST_SWEEP: if (pick) begin
               state_q      <= ST_IDLE;
               done         <= 1'b1;
               victim       <= ptr;
               victim_dirty <= cur.wr | cur.modf;
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/clock_victim_sel_chk.sv
module clock_victim_sel_chk
   import cvs_pkg::*;
#(
   parameter int NFRAMES = 8,
   localparam int IDX_W  = (NFRAMES > 1) ? $clog2(NFRAMES) : 1
) (
   input logic                      clk,
   input logic                      rst_n,
   input logic                      req,
   input logic                      busy,
   input logic                      done,
   input logic [IDX_W-1:0]          victim,
   input logic [IDX_W-1:0]          ptr,
   input frame_bits_t [NFRAMES-1:0] frames
);
   localparam int BOUND = 2 * NFRAMES + 1;
   int unsigned sweep_len;

   always_ff @(posedge clk) begin
      if (!rst_n)    sweep_len <= 0;
      else if (busy) sweep_len <= sweep_len + 1;
      else           sweep_len <= 0;
   end

   AST_DONE_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done); // R4
   AST_DONE_ENDS_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy); // R6
   AST_BUSY_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> $past(req)); // R6
   AST_HAND_PAST_VICTIM: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> ptr == ((victim == IDX_W'(NFRAMES - 1)) ? '0 : victim + 1'b1)); // R7
   AST_VICTIM_LOADED: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (frames[victim].used && !frames[victim].wr && !frames[victim].modf)); // R8
   AST_SWEEP_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
      sweep_len <= BOUND); // R10
endmodule

bind clock_victim_sel clock_victim_sel_chk #(.NFRAMES(NFRAMES)) u_chk (
   .clk(clk), .rst_n(rst_n), .req(req), .busy(busy), .done(done),
   .victim(victim), .ptr(ptr), .frames(frames)
);

// File: tb/clock_victim_sel_test.sv
module clock_victim_sel_test;
   localparam int N = 4;
   localparam int IW = 2;

   logic clk = 1'b0, rst_n = 1'b0;
   logic mode_third = 1'b1, ref_valid = 1'b0, ref_write = 1'b0, req = 1'b0;
   logic [IW-1:0] ref_frame = '0;
   logic busy, done, victim_dirty;
   logic [IW-1:0] victim;
   int tests = 0, fails = 0;

   always #10 clk = ~clk;

   clock_victim_sel #(.NFRAMES(N)) uut (
      .clk(clk), .rst_n(rst_n), .mode_third(mode_third), .ref_valid(ref_valid),
      .ref_frame(ref_frame), .ref_write(ref_write), .req(req), .busy(busy),
      .done(done), .victim(victim), .victim_dirty(victim_dirty)
   );

   // vector: [11:10] op 0=read 1=write 2=request, [9:8] frame, [7] mode,
   //         [6:5] expected victim, [4] expected dirty, [3:0] expected examinations
   localparam logic [11:0] VECS [12] = '{
      {2'd1, 2'd0, 1'b1, 2'd0, 1'b0, 4'd0},
      {2'd0, 2'd1, 1'b1, 2'd0, 1'b0, 4'd0},
      {2'd1, 2'd2, 1'b1, 2'd0, 1'b0, 4'd0},
      {2'd0, 2'd3, 1'b1, 2'd0, 1'b0, 4'd0},
      {2'd2, 2'd0, 1'b1, 2'd1, 1'b0, 4'd6},   // R2 R3 pass then select
      {2'd2, 2'd0, 1'b1, 2'd3, 1'b0, 4'd2},   // R7 R8
      {2'd2, 2'd0, 1'b1, 2'd0, 1'b1, 4'd1},   // R3 remembered dirty
      {2'd2, 2'd0, 1'b1, 2'd2, 1'b1, 4'd2},   // R3 R4
      {2'd1, 2'd1, 1'b0, 2'd0, 1'b0, 4'd0},
      {2'd2, 2'd0, 1'b0, 2'd3, 1'b0, 4'd5},   // R5 wrap
      {2'd2, 2'd0, 1'b0, 2'd0, 1'b0, 4'd1},   // R5
      {2'd2, 2'd0, 1'b0, 2'd1, 1'b1, 4'd1}    // R5 write kept, R1
   };

   task automatic check(input bit ok, input string tag, input int act, input int exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic do_ref(input logic [IW-1:0] f, input logic w);
      @(negedge clk);
      ref_valid = 1'b1; ref_frame = f; ref_write = w;
      @(negedge clk);
      ref_valid = 1'b0; ref_write = 1'b0;
   endtask

   // issues a request; returns examinations until done, the victim and dirty flag
   task automatic do_req(output int cyc, output int vic, output int dirty,
                         input int midref);
      @(negedge clk);
      req = 1'b1;
      @(negedge clk);
      req = 1'b0;
      check(busy == 1'b1, "R6 busy after req", busy, 1);
      cyc = 0;
      while (!done && cyc < 20) begin
         if (midref >= 0 && cyc == 1) begin
            ref_valid = 1'b1; ref_frame = IW'(midref); ref_write = 1'b0;
         end else if (midref == -2 && cyc == 3) begin
            req = 1'b1;
         end else begin
            ref_valid = 1'b0; req = 1'b0;
         end
         @(negedge clk);
         cyc++;
      end
      ref_valid = 1'b0; req = 1'b0;
      vic = victim; dirty = victim_dirty;
      check(busy == 1'b0, "R6 busy low at done", busy, 0);
   endtask

   task automatic do_reset();
      @(negedge clk); rst_n = 1'b0;
      @(negedge clk); @(negedge clk); rst_n = 1'b1;
   endtask

   initial begin : watchdog
      repeat (5000) @(posedge clk);
      fails++; tests++;
      $display("FAIL watchdog: actual 1 expected 0");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin : main
      int cyc, vic, dirty;
      do_reset();
      // R11 reset state and first selection
      check(busy == 1'b0 && done == 1'b0, "R11 idle after reset", {busy, done}, 0);
      do_req(cyc, vic, dirty, -1);
      check(cyc == 1 && vic == 0 && dirty == 0, "R11 first pick", cyc*100 + vic*10 + dirty, 100);

      do_reset();
      for (int i = 0; i < 12; i++) begin
         logic [11:0] v;
         v = VECS[i];
         mode_third = v[7];
         if (v[11:10] != 2'd2) begin
            do_ref(v[9:8], v[10]);
         end else begin
            do_req(cyc, vic, dirty, -1);
            check(cyc == int'(v[3:0]), $sformatf("R6 latency vec %0d", i), cyc, v[3:0]);
            check(vic == int'(v[6:5]), $sformatf("R4 victim vec %0d", i), vic, v[6:5]);
            check(dirty == int'(v[4]), $sformatf("R4 dirty vec %0d", i), dirty, v[4]);
         end
      end

      // R9: reference during a sweep to a frame not yet examined
      do_reset();
      mode_third = 1'b1;
      do_ref(2'd0, 1'b0); do_ref(2'd1, 1'b0); do_ref(2'd2, 1'b0);
      do_req(cyc, vic, dirty, 3);
      check(vic == 0 && cyc == 5, "R9 mid-sweep reference", vic*10 + cyc, 5);

      // R10 worst case, R12 stray request during sweep
      do_reset();
      for (int f = 0; f < N; f++) do_ref(IW'(f), 1'b1);
      do_req(cyc, vic, dirty, -2);
      check(cyc == 2*N + 1, "R10 longest sweep", cyc, 2*N + 1);
      check(vic == 0 && dirty == 1, "R10 worst-case victim", vic*10 + dirty, 1);
      @(negedge clk);
      check(busy == 1'b0, "R12 request while busy ignored", busy, 0);

      // R1: read after write keeps write flag (second-chance reports it)
      do_reset();
      mode_third = 1'b0;
      do_ref(2'd0, 1'b1); do_ref(2'd0, 1'b0);
      do_req(cyc, vic, dirty, -1);
      check(vic == 1 && dirty == 0, "R1 referenced frame skipped", vic*10 + dirty, 10);
      do_req(cyc, vic, dirty, -1);
      do_req(cyc, vic, dirty, -1);
      do_req(cyc, vic, dirty, -1);
      check(vic == 0 && dirty == 1, "R1 write flag kept by read", vic*10 + dirty, 1);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule